// File: doc/BRIEF.md
# Periodic Interrupt Rate Generator

This block derives a periodic event from a 32.768 kHz timebase. The timebase arrives as a one-cycle clock-enable strobe in the system clock domain. Each strobe advances a free-running tick counter. A 4-bit rate code selects a power-of-two period. An event fires on every tick that brings the counter to a multiple of that period. Because events are aligned to the free-running counter, they are not timed from the moment the code was written, and changing the code never restarts the count.

Two enables gate the generator. The periodic-interrupt enable lets the event reach `periodic_evt`, where downstream logic would set an interrupt flag. The square-wave enable lets the same boundary reach `sqw_pulse`, which is a single pulse per period and not a 50% duty waveform. Rate code 0 stops both outputs. The two lowest active codes are remapped to longer periods, because the plain formula would give periods too short to be useful.

Top module: `pit_rate_gen`

## Requirements
- R1: While `rst_n` is low, both outputs are 0 and the tick counter is cleared. After reset, the first boundary with rate code 3 (period 4) falls on the 4th strobe of `tick32_en`.
- R2: For a rate code n in 3..15, an event fires once every 2^(n-1) strobes of `tick32_en`.
- R3: Rate code 1 gives a period of 128 strobes, and rate code 2 gives a period of 256 strobes.
- R4: Rate code 0 produces no pulse on either output, whatever the enables are.
- R5: With `pie_en` and `sqw_en` both low, neither output pulses, for any rate code.
- R6: An event fires exactly on the strobe after which the count of strobes since reset is a multiple of the period. The counter moves only on a strobe.
- R7: A new rate code takes effect at the next multiple of its own period in the running count. The count is not reset when the code changes.
- R8: `periodic_evt` pulses on a boundary only when `pie_en` is high. `sqw_pulse` pulses on a boundary only when `sqw_en` is high. With both enables high, the two outputs pulse together.
- R9: Each pulse lasts exactly one system clock cycle. It appears in the cycle that follows the clock edge on which the strobe was sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick32_en | input | 1 | One-cycle strobe per 32.768 kHz period |
| rate_code | input | 4 | Logarithmic period select (0 = off) |
| pie_en | input | 1 | Periodic event enable |
| sqw_en | input | 1 | Square-wave pulse enable |
| periodic_evt | output | 1 | One-cycle periodic event |
| sqw_pulse | output | 1 | One-cycle square-wave pulse |

## Verification
Some properties are checked on every cycle. Each pulse lasts a single cycle and follows a strobe. A pulse needs a nonzero code and its own enable in the previous cycle. Every event lands where the counter's low bits are zero, and the counter holds its value between strobes. Other behaviour needs a long scenario to show: the exact period of each code, the remapping of codes 1 and 2, and the way a mid-stream code change lines up with the running count. The bench shows these by comparing every strobe against a count-since-reset model.

// File: rtl/pit_rate_gen.sv
module pit_rate_gen #(
  parameter int RATE_W = 4,
  parameter int CNT_W  = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick32_en,
  input  logic [RATE_W-1:0] rate_code,
  input  logic              pie_en,
  input  logic              sqw_en,
  output logic              periodic_evt,
  output logic              sqw_pulse
);
  localparam logic [RATE_W-1:0] REMAP_OFS = RATE_W'(7);

  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  cnt_nxt;
  logic [CNT_W-1:0]  mask;
  logic [RATE_W-1:0] eff_code;
  logic [RATE_W-1:0] shamt;
  logic              run;
  logic              hit;

  assign eff_code = (rate_code == RATE_W'(1) || rate_code == RATE_W'(2))
                    ? rate_code + REMAP_OFS : rate_code;
  assign shamt    = eff_code - RATE_W'(1);
  assign mask     = (CNT_W'(1) << shamt) - CNT_W'(1);
  assign cnt_nxt  = cnt + CNT_W'(1);
  assign run      = (pie_en | sqw_en) && (rate_code != '0);
  assign hit      = tick32_en && run && ((cnt_nxt & mask) == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt          <= '0;
      periodic_evt <= 1'b0;
      sqw_pulse    <= 1'b0;
    end else begin
      if (tick32_en) cnt <= cnt_nxt;
      periodic_evt <= hit & pie_en;
      sqw_pulse    <= hit & sqw_en;
    end
  end
endmodule

module pit_rate_gen_chk #(
  parameter int RATE_W = 4,
  parameter int CNT_W  = 15
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick32_en,
  input logic [RATE_W-1:0] rate_code,
  input logic              pie_en,
  input logic              sqw_en,
  input logic              periodic_evt,
  input logic              sqw_pulse,
  input logic [CNT_W-1:0]  cnt
);
  p_one_cycle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    periodic_evt |=> !periodic_evt);
  p_sqw_one_cycle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sqw_pulse |=> !sqw_pulse);
  p_after_tick_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (periodic_evt || sqw_pulse) |-> $past(tick32_en));
  p_code_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (periodic_evt || sqw_pulse) |-> ($past(rate_code) != '0));
  p_pie_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    periodic_evt |-> $past(pie_en));
  p_sqw_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sqw_pulse |-> $past(sqw_en));
  p_aligned_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (periodic_evt || sqw_pulse) |-> (cnt[1:0] == 2'b00));
  p_cnt_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !tick32_en |=> $stable(cnt));
endmodule

bind pit_rate_gen pit_rate_gen_chk #(.RATE_W(RATE_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick32_en(tick32_en), .rate_code(rate_code),
  .pie_en(pie_en), .sqw_en(sqw_en), .periodic_evt(periodic_evt),
  .sqw_pulse(sqw_pulse), .cnt(cnt)
);

// File: tb/pit_rate_gen_bench.sv
module pit_rate_gen_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick32_en = 1'b0;
  logic [3:0] rate_code = 4'd0;
  logic       pie_en = 1'b0;
  logic       sqw_en = 1'b0;
  logic       periodic_evt;
  logic       sqw_pulse;

  int tests = 0;
  int fails = 0;
  int tc = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pit_rate_gen u_pit_rate_gen (
    .clk(clk), .rst_n(rst_n), .tick32_en(tick32_en), .rate_code(rate_code),
    .pie_en(pie_en), .sqw_en(sqw_en), .periodic_evt(periodic_evt),
    .sqw_pulse(sqw_pulse)
  );

  function automatic int period_of(input logic [3:0] c);
    if (c == 0) return 0;
    if (c == 1) return 128;
    if (c == 2) return 256;
    return 1 << (c - 1);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One strobe; returns outputs seen after it and whether they dropped a cycle later.
  task automatic strobe(output bit e, output bit s, output bit stuck);
    @(negedge clk) tick32_en = 1'b1;
    @(negedge clk) tick32_en = 1'b0;
    e = periodic_evt; s = sqw_pulse;
    @(negedge clk);
    stuck = periodic_evt | sqw_pulse;
    tc = (tc + 1) % 32768;
  endtask

  // Runs n strobes, compares every one with the model, reports per-output mismatches.
  task automatic run(input int n, input logic [3:0] c, input bit pie, input bit sqw,
                     input string req, input int min_events);
    int mis = 0, events = 0, longp = 0;
    int p = period_of(c);
    rate_code = c; pie_en = pie; sqw_en = sqw;
    for (int i = 0; i < n; i++) begin
      bit e, s, st, b;
      b = (p != 0) && (pie || sqw) && (((tc + 1) % p) == 0);
      strobe(e, s, st);
      if (e !== (b & pie) || s !== (b & sqw)) mis++;
      if (st) longp++;
      if (e || s) events++;
    end
    check(mis == 0, req, mis, 0);
    check(longp == 0, "R9 pulse width", longp, 0);
    check(events >= min_events, req, events, min_events);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; tc = 0;
    repeat (3) @(negedge clk);
    check(periodic_evt == 0 && sqw_pulse == 0, "R1 reset outputs", periodic_evt + sqw_pulse, 0);
    rst_n = 1'b1;
  endtask

  task automatic t_first_boundary;
    int first = -1;
    rate_code = 4'd3; pie_en = 1'b1; sqw_en = 1'b0;
    for (int i = 1; i <= 4; i++) begin
      bit e, s, st;
      strobe(e, s, st);
      if (e && first < 0) first = i;
    end
    check(first == 4, "R1 first event on 4th strobe", first, 4);
  endtask

  task automatic t_no_strobe;
    int seen = 0;
    rate_code = 4'd3; pie_en = 1'b1;
    repeat (20) begin
      @(negedge clk);
      if (periodic_evt) seen++;
    end
    check(seen == 0, "R6 no event without strobe", seen, 0);
  endtask

  task automatic t_rate_change;
    bit e, s, st;
    int first = -1;
    rate_code = 4'd3; pie_en = 1'b1; sqw_en = 1'b0;
    while ((tc % 16) != 5) strobe(e, s, st);
    rate_code = 4'd5;
    for (int i = 1; i <= 16; i++) begin
      strobe(e, s, st);
      if (e && first < 0) first = i;
    end
    check(first == 11, "R7 code change aligned to running count", first, 11);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_first_boundary();
        t_no_strobe();
        run(40, 4'd3, 1'b1, 1'b0, "R2 code 3", 10);
        run(64, 4'd4, 1'b1, 1'b0, "R2 code 4", 8);
        run(130, 4'd6, 1'b1, 1'b0, "R6 code 6 alignment", 4);
        run(300, 4'd1, 1'b1, 1'b0, "R3 code 1 period 128", 2);
        run(600, 4'd2, 1'b1, 1'b0, "R3 code 2 period 256", 2);
        run(50, 4'd0, 1'b1, 1'b1, "R4 code 0 silent", 0);
        run(50, 4'd3, 1'b0, 1'b0, "R5 enables off", 0);
        run(40, 4'd3, 1'b0, 1'b1, "R8 sqw only", 10);
        run(40, 4'd3, 1'b1, 1'b1, "R8 both enables", 10);
        t_rate_change();
        run(16400, 4'd15, 1'b1, 1'b0, "R2 code 15 period 16384", 1);
        done = 1'b1;
      end
      begin
        for (int i = 0; i < 190000 && !done; i++) @(posedge clk);
        if (!done) begin
          tests++; fails++;
          $display("FAIL watchdog actual=timeout expected=done");
        end
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule